// File: doc/BRIEF.md
# Output Occupancy Sensor and Route Chooser

This block keeps, for every output port of a router, a count of the flits currently committed to a fixed observation segment of the outgoing channel. When a head flit is routed to an output, the whole packet length is charged to that output at once, before any flit has moved. Each flit that leaves the far end of the segment takes one unit back off the count. A flit leaves when the valid and ready signals between the last stage of the segment and the stage after it are both high. That leave pulse travels back to the router over a wire, and this delay is modelled with a shift register whose depth is half the channel delay, rounded up.

The counts drive an adaptive route decision for each new packet. Two candidates are given: a minimal route and a non-minimal route, each with its output port and its hop count. Each candidate's occupancy is multiplied by its hop count, and the cheaper candidate wins. A tie goes to the minimal route. The decision is registered, and it holds until the next request, so it is never revisited. Neither input side has back-pressure. Route events, segment handshakes and decision requests are all taken in the cycle they are presented, so the block drives no ready toward its sources.

Top module: `occ_route_sensor`

## Requirements
- R1: After reset every occupancy count is 0, `dec_done` is 0 and `dec_take_alt` is 0.
- R2: A cycle with `route_valid` high adds `route_len` to the count of output `route_port`, and the sum is visible after the next rising edge.
- R3: A leave event for output i needs both `seg_valid[i]` and `seg_ready[i]` high in the same cycle. Either signal high alone leaves the count unchanged.
- R4: A leave event in cycle t lowers the count by one at the edge that ends cycle t+LEAVE_DLY, where LEAVE_DLY = ceil(CHAN_DLY/2).
- R5: When a charge and a delayed leave reach the same output in one cycle, both are applied at that edge, giving count + len − 1.
- R6: A count never goes below 0. A leave reaching an empty count with no charge leaves it at 0.
- R7: A count saturates at 2^CNT_W − 1 and never wraps past it.
- R8: When `dec_valid` is high, one edge later `dec_done` is 1. At that point `dec_take_alt` is 1 exactly when occ[alt_port]·alt_hops < occ[min_port]·min_hops, using the counts held in the request cycle. A tie gives 0 (minimal).
- R9: `dec_done` is 0 in any cycle after one with no request, and `dec_take_alt` then keeps its last value.
- R10: The count of output i appears on `occ_flat[i*CNT_W +: CNT_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| route_valid | input | 1 | Head flit routed this cycle |
| route_port | input | OUT_W | Output the head flit was routed to |
| route_len | input | LEN_W | Packet length in flits |
| seg_valid | input | NUM_OUT | Valid between the last segment stage and the next stage, per output |
| seg_ready | input | NUM_OUT | Ready between the last segment stage and the next stage, per output |
| dec_valid | input | 1 | Route decision request |
| min_port | input | OUT_W | Output on the minimal route |
| min_hops | input | HOP_W | Hop count of the minimal route |
| alt_port | input | OUT_W | Output on the non-minimal route |
| alt_hops | input | HOP_W | Hop count of the non-minimal route |
| occ_flat | output | NUM_OUT*CNT_W | Packed occupancy counts |
| dec_done | output | 1 | Decision valid this cycle |
| dec_take_alt | output | 1 | 1 = non-minimal route chosen, 0 = minimal |

## Verification
The bench builds the block with four outputs, a 5-bit count, 3-bit lengths, 2-bit hop counts and a channel delay of 5, which gives a leave delay of 3. The narrow count lets a burst of charges drive a counter into saturation within a handful of cycles. A drain phase then pins the counts at zero while leave pulses keep arriving. Small counts and hop counts make equal weighted loads frequent, so the tie rule is exercised often. The odd channel delay tests the rounding up of the leave delay, and the three-stage return path keeps several leave pulses in flight together with new charges.

// File: rtl/occ_pkg.sv
package occ_pkg;
  // Saturating update of one occupancy count: charge a packet, drop one flit.
  function automatic logic [31:0] occ_step(input logic [31:0] cur,
                                          input logic [31:0] add,
                                          input logic        dec,
                                          input logic [31:0] maxv);
    logic [32:0] s;
    s = {1'b0, cur} + {1'b0, add};
    if (dec && s != 33'd0) s = s - 33'd1;
    if (s > {1'b0, maxv}) s = {1'b0, maxv};
    return s[31:0];
  endfunction
endpackage

// File: rtl/occ_leave_delay.sv
module occ_leave_delay #(
  parameter int NUM_OUT = 4,
  parameter int DLY     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OUT-1:0] hs_valid,
  input  logic [NUM_OUT-1:0] hs_ready,
  output logic [NUM_OUT-1:0] leave
);
  logic [NUM_OUT-1:0] stage [DLY];

  // R3: a flit leaves only when both sides of the handshake agree
  always_ff @(posedge clk) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= hs_valid & hs_ready;
  end

  for (genvar s = 1; s < DLY; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage[s] <= '0;
      else        stage[s] <= stage[s-1];
    end
  end

  assign leave = stage[DLY-1];

  // R3
  lone_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hs_valid & hs_ready) == '0) |=> (stage[0] == '0));
endmodule

// File: rtl/occ_counter.sv
module occ_counter
  import occ_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             charge,
  input  logic [LEN_W-1:0] len,
  input  logic             leave,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [31:0] MAXV = 32'((64'd1 << CNT_W) - 64'd1);

  logic [31:0] nxt;
  always_comb nxt = occ_step(32'(cnt), charge ? 32'(len) : 32'd0, leave, MAXV);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt[CNT_W-1:0];
  end

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !charge) |=> (cnt == '0));
  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt) == MAXV && !leave) |=> (32'(cnt) == MAXV));
  // R2
  charge_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (charge && !leave && (32'(cnt) + 32'(len) <= MAXV))
      |=> (32'(cnt) == 32'($past(cnt)) + 32'($past(len))));
endmodule

// File: rtl/occ_chooser.sv
module occ_chooser #(
  parameter int CNT_W = 8,
  parameter int HOP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [CNT_W-1:0] min_occ,
  input  logic [HOP_W-1:0] min_hops,
  input  logic [CNT_W-1:0] alt_occ,
  input  logic [HOP_W-1:0] alt_hops,
  output logic             done,
  output logic             take_alt
);
  localparam int PW = CNT_W + HOP_W;
  logic [PW-1:0] w_min, w_alt;

  always_comb begin
    w_min = PW'(min_occ) * PW'(min_hops);
    w_alt = PW'(alt_occ) * PW'(alt_hops);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      take_alt <= 1'b0;
    end else begin
      done <= req;
      if (req) take_alt <= (w_alt < w_min); // tie stays minimal
    end
  end

  // R9
  decision_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (!done && $stable(take_alt)));
  // R8
  done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> done);
endmodule

// File: rtl/occ_route_sensor.sv
module occ_route_sensor #(
  parameter int NUM_OUT  = 4,
  parameter int CNT_W    = 8,
  parameter int LEN_W    = 4,
  parameter int HOP_W    = 3,
  parameter int CHAN_DLY = 4,
  localparam int OUT_W     = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
  localparam int LEAVE_DLY = (CHAN_DLY + 1) / 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     route_valid,
  input  logic [OUT_W-1:0]         route_port,
  input  logic [LEN_W-1:0]         route_len,
  input  logic [NUM_OUT-1:0]       seg_valid,
  input  logic [NUM_OUT-1:0]       seg_ready,
  input  logic                     dec_valid,
  input  logic [OUT_W-1:0]         min_port,
  input  logic [HOP_W-1:0]         min_hops,
  input  logic [OUT_W-1:0]         alt_port,
  input  logic [HOP_W-1:0]         alt_hops,
  output logic [NUM_OUT*CNT_W-1:0] occ_flat,
  output logic                     dec_done,
  output logic                     dec_take_alt
);
  logic [NUM_OUT-1:0] leave_d;
  logic [CNT_W-1:0]   occ [NUM_OUT];

  // R4: return path of the leave pulse
  occ_leave_delay #(.NUM_OUT(NUM_OUT), .DLY(LEAVE_DLY)) u_dly (
    .clk(clk), .rst_n(rst_n),
    .hs_valid(seg_valid), .hs_ready(seg_ready), .leave(leave_d)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    logic hit;
    assign hit = route_valid && (route_port == OUT_W'(i));
    occ_counter #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .charge(hit), .len(route_len), .leave(leave_d[i]), .cnt(occ[i])
    );
    // R10
    assign occ_flat[i*CNT_W +: CNT_W] = occ[i];
  end

  occ_chooser #(.CNT_W(CNT_W), .HOP_W(HOP_W)) u_choose (
    .clk(clk), .rst_n(rst_n), .req(dec_valid),
    .min_occ(occ[min_port]), .min_hops(min_hops),
    .alt_occ(occ[alt_port]), .alt_hops(alt_hops),
    .done(dec_done), .take_alt(dec_take_alt)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (occ_flat == '0 && !dec_done && !dec_take_alt));
endmodule

// File: tb/occ_route_sensor_test.sv
module occ_route_sensor_test;
  localparam int NO = 4, CW = 5, LW = 3, HW = 2, CD = 5;
  localparam int OW = 2, LD = (CD + 1) / 2, MAXC = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic route_valid = 0, dec_valid = 0;
  logic [OW-1:0] route_port = 0, min_port = 0, alt_port = 0;
  logic [LW-1:0] route_len = 0;
  logic [HW-1:0] min_hops = 0, alt_hops = 0;
  logic [NO-1:0] seg_valid = 0, seg_ready = 0;
  logic [NO*CW-1:0] occ_flat;
  logic dec_done, dec_take_alt;

  int checks = 0, fails = 0;
  bit finished = 0;
  int m_cnt [NO];
  logic [NO-1:0] m_pipe [LD];
  bit e_done = 0, e_alt = 0;

  always #5 clk = ~clk;

  occ_route_sensor #(.NUM_OUT(NO), .CNT_W(CW), .LEN_W(LW), .HOP_W(HW), .CHAN_DLY(CD)) uut (
    .clk(clk), .rst_n(rst_n), .route_valid(route_valid), .route_port(route_port),
    .route_len(route_len), .seg_valid(seg_valid), .seg_ready(seg_ready),
    .dec_valid(dec_valid), .min_port(min_port), .min_hops(min_hops),
    .alt_port(alt_port), .alt_hops(alt_hops), .occ_flat(occ_flat),
    .dec_done(dec_done), .dec_take_alt(dec_take_alt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < NO; i++)
      chk("R2_R3_R4_R5_R6_R7_R10 occupancy", int'(occ_flat[i*CW +: CW]), m_cnt[i]);
    chk("R8_R9 dec_done", int'(dec_done), int'(e_done));
    chk("R8_R9 dec_take_alt", int'(dec_take_alt), int'(e_alt));
  endtask

  // Advance the reference by one edge using the inputs now applied.
  task automatic model_step();
    logic [NO-1:0] arriving;
    arriving = m_pipe[LD-1];
    if (dec_valid) begin
      int wm, wa;
      wm = m_cnt[min_port] * int'(min_hops);
      wa = m_cnt[alt_port] * int'(alt_hops);
      e_alt = (wa < wm); // R8 tie -> minimal
    end
    e_done = dec_valid; // R9
    for (int s = LD - 1; s > 0; s--) m_pipe[s] = m_pipe[s-1];
    m_pipe[0] = seg_valid & seg_ready; // R3
    for (int i = 0; i < NO; i++) begin
      int v;
      v = m_cnt[i];
      if (route_valid && int'(route_port) == i) v += int'(route_len);
      if (arriving[i]) v -= 1;
      if (v < 0) v = 0;           // R6
      if (v > MAXC) v = MAXC;     // R7
      m_cnt[i] = v;
    end
  endtask

  task automatic drive_random(input int pc, input int pl);
    route_valid = ($urandom_range(99) < pc);
    route_port  = OW'($urandom_range(NO - 1));
    route_len   = LW'($urandom_range((1 << LW) - 1));
    seg_valid   = NO'($urandom);
    seg_ready   = NO'($urandom);
    for (int i = 0; i < NO; i++)
      if ($urandom_range(99) >= pl) seg_ready[i] = 1'b0;
    dec_valid = ($urandom_range(99) < 50);
    min_port  = OW'($urandom_range(NO - 1));
    alt_port  = OW'($urandom_range(NO - 1));
    min_hops  = HW'($urandom_range((1 << HW) - 1));
    alt_hops  = HW'($urandom_range((1 << HW) - 1));
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NO; i++) m_cnt[i] = 0;
    for (int s = 0; s < LD; s++) m_pipe[s] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    compare_all();
    // R4: a single handshake on output 1 after charging it
    route_valid = 1; route_port = 1; route_len = 3;
    model_step(); @(negedge clk); compare_all();
    route_valid = 0; seg_valid = 4'b0010; seg_ready = 4'b0010;
    model_step(); @(negedge clk); compare_all();
    seg_valid = 4'b0100; seg_ready = 4'b1000; // R3 lone sides, no effect
    for (int k = 0; k < LD + 2; k++) begin
      model_step(); @(negedge clk); compare_all();
      seg_valid = 0; seg_ready = 0;
    end
    chk("R4 delayed leave", int'(occ_flat[1*CW +: CW]), 2);
    // R8 tie: both weighted loads zero -> minimal
    dec_valid = 1; min_port = 0; alt_port = 3; min_hops = 1; alt_hops = 3;
    model_step(); @(negedge clk); compare_all();
    chk("R8 tie minimal", int'(dec_take_alt), 0);
    dec_valid = 0;
    // mixed, then saturating, then draining
    for (int c = 0; c < 3000; c++) begin
      if (c < 1000)      drive_random(40, 50);
      else if (c < 1600) drive_random(90, 10);
      else if (c < 2300) drive_random(5, 95);
      else               drive_random(50, 60);
      model_step();
      @(negedge clk);
      compare_all();
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule